// File: doc/BRIEF.md
# Cartridge bank-switch controller

This block sits on the external bus of an 8048-class microcontroller inside a game cartridge and turns one large ROM into two independent views. Program fetches (PSEN low) see a 4 KB window whose upper address bits come from a code-bank register. A port bit can force that window to the topmost bank, so the machine starts from a known bank out of reset. Data reads through the external-data instruction (RD low) can instead be steered into the ROM by a second port bit. In that case the upper address bits come from a separate data-bank register, so any byte of the ROM can be read from any code location.

Besides the two bank registers, a small register window in external data space holds an output register and a read-only input register. The output register drives the pins of a bit-serial EEPROM and a serial TX line. The input register returns the EEPROM data-out pin. Software reaches all four registers with ordinary external-data reads and writes while the cartridge-enable port bit is low. The bus control signals are sampled on the block clock. The low address byte is captured when ALE falls, and a write takes effect when WR returns high.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset the code bank, data bank and output register are 00h, so `tx` is 1 and `ee_cs`, `ee_clk`, `ee_di` are 0.
- R2: The low address byte on `bus_in` is captured on the clock where ALE is first seen low after being high. Addresses 80h–FFh (bit 7 set) form the register window, and bits 1:0 select the register: 0 code bank, 1 data bank, 2 output, 3 input. Accesses with bit 7 clear touch no register.
- R3: A write takes effect on the clock where WR is first seen high after being low. It uses the last bus value sampled while WR was low. Each writable register reads back the last value written to it, and the output register reads back as {4'b0, value[3:0]}.
- R4: `rom_addr_hi[3:0]` always equals `p2_low`. Outside a ROM data read, `rom_addr_hi[11:4]` is FFh when `p1_code_top` is 1 and the code bank otherwise.
- R5: A ROM data read is RD low with `p1_data_sel_n` 0 and `p1_cart_en_n` 0. During it, `rom_addr_hi[11:4]` is the data bank, `rom_oe_n` is 0 and `bus_oe` is 0.
- R6: `tx` is the inverse of output bit 0. `ee_cs`, `ee_clk` and `ee_di` follow output bits 1, 2 and 3.
- R7: The input register reads as {7'b0, `ee_do`}, and writes to it change nothing.
- R8: While `p1_cart_en_n` is 1, writes change no register, and neither a register read nor a ROM data read takes place.
- R9: `bus_oe` is 1 only for RD low with `p1_data_sel_n` 1, `p1_cart_en_n` 0 and a window address. `rom_oe_n` is 0 only for PSEN low or a ROM data read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| bus_in | input | 8 | Multiplexed address/data bus, input side |
| bus_out | output | 8 | Register read data |
| bus_oe | output | 1 | Drive enable for `bus_out` |
| ale | input | 1 | Address latch enable |
| psen_n | input | 1 | Program fetch strobe, active low |
| rd_n | input | 1 | External data read strobe, active low |
| wr_n | input | 1 | External data write strobe, active low |
| p1_code_top | input | 1 | Forces the code window to the top bank |
| p1_data_sel_n | input | 1 | Low steers RD reads to the ROM |
| p1_cart_en_n | input | 1 | Cartridge enable for external data accesses, active low |
| p2_low | input | 4 | Port 2 low nibble, ROM address A8–A11 |
| ee_do | input | 1 | EEPROM data-out pin |
| rom_addr_hi | output | 12 | ROM address A8–A19 |
| rom_oe_n | output | 1 | ROM output enable, active low |
| tx | output | 1 | Serial TX line |
| ee_cs | output | 1 | EEPROM chip select |
| ee_clk | output | 1 | EEPROM clock |
| ee_di | output | 1 | EEPROM data-in |

## Verification
The hardest situation to observe is a write that must be dropped: a write outside the window, to the input register, or with the cartridge disabled. Such a write leaves no trace until a later read of the right register, and only if that read is itself enabled and in the window. The stimulus draws the full 8-bit address range, toggles the enable and steering bits on every operation, and interleaves reads at random mirror addresses. A dropped write then shows up as a mismatch against the bench's register model at some later read, and the directed cases also check such writes right away.

// File: rtl/cart_pkg.sv
package cart_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int BANK_W = 8;
    localparam int PAGE_W = 4;
    localparam int OUT_W  = 4;

    typedef enum logic [1:0] {
        IDX_CODE = 2'd0,
        IDX_DATA = 2'd1,
        IDX_OUT  = 2'd2,
        IDX_IN   = 2'd3
    } reg_idx_e;
endpackage

// File: rtl/cart_bus_sync.sv
module cart_bus_sync #(
    parameter int AW = cart_pkg::ADDR_W,
    parameter int DW = cart_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ale,
    input  logic          wr_n,
    input  logic [DW-1:0] bus_in,
    output logic [AW-1:0] addr,
    output logic          wr_commit,
    output logic [DW-1:0] wdata
);
    typedef struct packed {
        logic          ale_prev;
        logic          wr_n_prev;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } sync_t;

    sync_t s_d, s_q;
    logic  ale_fall;

    assign ale_fall = s_q.ale_prev && !ale;

    always_comb begin
        s_d           = s_q;
        s_d.ale_prev  = ale;
        s_d.wr_n_prev = wr_n;
        if (ale_fall) s_d.addr  = bus_in[AW-1:0];
        if (!wr_n)    s_d.wdata = bus_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ale_prev  <= 1'b0;
            s_q.wr_n_prev <= 1'b1;
            s_q.addr      <= '0;
            s_q.wdata     <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign addr      = s_q.addr;
    assign wdata     = s_q.wdata;
    assign wr_commit = !s_q.wr_n_prev && wr_n;

    // R2: the address captured at ALE fall is the bus value of that clock
    a_r2_addr_latch: assert property (@(posedge clk) disable iff (!rst_n)
        ale_fall |=> (addr == $past(bus_in[AW-1:0])));

    // R3: a commit uses data sampled while WR was still low
    a_r3_commit_data: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n) |=> (wdata == $past(bus_in)));
endmodule

// File: rtl/cart_regfile.sv
module cart_regfile #(
    parameter int AW = cart_pkg::ADDR_W,
    parameter int DW = cart_pkg::DATA_W,
    parameter int BW = cart_pkg::BANK_W,
    parameter int OW = cart_pkg::OUT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr_commit,
    input  logic [DW-1:0] wdata,
    input  logic          cart_en_n,
    input  logic          ee_do,
    output logic [BW-1:0] code_bank,
    output logic [BW-1:0] data_bank,
    output logic [OW-1:0] out_bits,
    output logic [DW-1:0] rdata,
    output logic          in_window
);
    import cart_pkg::*;

    typedef struct packed {
        logic [BW-1:0] code;
        logic [BW-1:0] data;
        logic [OW-1:0] outr;
    } regs_t;

    regs_t    r_d, r_q;
    reg_idx_e idx;
    logic     we;

    assign in_window = addr[AW-1];
    assign idx       = reg_idx_e'(addr[1:0]);
    assign we        = wr_commit && !cart_en_n && in_window;

    always_comb begin
        r_d = r_q;
        if (we) begin
            case (idx)
                IDX_CODE: r_d.code = wdata[BW-1:0];
                IDX_DATA: r_d.data = wdata[BW-1:0];
                IDX_OUT:  r_d.outr = wdata[OW-1:0];
                default:  r_d      = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (idx)
            IDX_CODE: rdata = DW'(r_q.code);
            IDX_DATA: rdata = DW'(r_q.data);
            IDX_OUT:  rdata = {{(DW-OW){1'b0}}, r_q.outr};
            default:  rdata = {{(DW-1){1'b0}}, ee_do};
        endcase
    end

    assign code_bank = r_q.code;
    assign data_bank = r_q.data;
    assign out_bits  = r_q.outr;

    // R8: with the cartridge disabled no register moves
    a_r8_disabled_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        cart_en_n |=> $stable({code_bank, data_bank, out_bits}));

    // R3: the code bank holds the committed byte
    a_r3_code_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (we && idx == IDX_CODE) |=> (code_bank == $past(wdata[BW-1:0])));

    // R2: a write outside the window leaves the registers alone
    a_r2_outside_window: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_window) |=> $stable({code_bank, data_bank, out_bits}));
endmodule

// File: rtl/cart_addr_map.sv
module cart_addr_map #(
    parameter int BW = cart_pkg::BANK_W,
    parameter int PW = cart_pkg::PAGE_W
) (
    input  logic [BW-1:0]    code_bank,
    input  logic [BW-1:0]    data_bank,
    input  logic [PW-1:0]    p2_low,
    input  logic             code_top,
    input  logic             data_sel_n,
    input  logic             cart_en_n,
    input  logic             psen_n,
    input  logic             rd_n,
    output logic [BW+PW-1:0] rom_addr_hi,
    output logic             rom_oe_n,
    output logic             data_rd
);
    logic [BW-1:0] bank;

    always_comb begin
        data_rd = !rd_n && !data_sel_n && !cart_en_n;
        if (data_rd)       bank = data_bank;
        else if (code_top) bank = '1;
        else               bank = code_bank;
        rom_addr_hi = {bank, p2_low};
        rom_oe_n    = !(!psen_n || data_rd);
    end
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl #(
    parameter int AW = cart_pkg::ADDR_W,
    parameter int DW = cart_pkg::DATA_W,
    parameter int BW = cart_pkg::BANK_W,
    parameter int PW = cart_pkg::PAGE_W,
    parameter int OW = cart_pkg::OUT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DW-1:0]    bus_in,
    output logic [DW-1:0]    bus_out,
    output logic             bus_oe,
    input  logic             ale,
    input  logic             psen_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic             p1_code_top,
    input  logic             p1_data_sel_n,
    input  logic             p1_cart_en_n,
    input  logic [PW-1:0]    p2_low,
    input  logic             ee_do,
    output logic [BW+PW-1:0] rom_addr_hi,
    output logic             rom_oe_n,
    output logic             tx,
    output logic             ee_cs,
    output logic             ee_clk,
    output logic             ee_di
);
    logic [AW-1:0] addr;
    logic          wr_commit;
    logic [DW-1:0] wdata;
    logic [BW-1:0] code_bank, data_bank;
    logic [OW-1:0] out_bits;
    logic [DW-1:0] rdata;
    logic          in_window;
    logic          data_rd;

    cart_bus_sync #(.AW(AW), .DW(DW)) u_sync (
        .clk(clk), .rst_n(rst_n), .ale(ale), .wr_n(wr_n), .bus_in(bus_in),
        .addr(addr), .wr_commit(wr_commit), .wdata(wdata)
    );

    cart_regfile #(.AW(AW), .DW(DW), .BW(BW), .OW(OW)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_commit(wr_commit),
        .wdata(wdata), .cart_en_n(p1_cart_en_n), .ee_do(ee_do),
        .code_bank(code_bank), .data_bank(data_bank), .out_bits(out_bits),
        .rdata(rdata), .in_window(in_window)
    );

    cart_addr_map #(.BW(BW), .PW(PW)) u_map (
        .code_bank(code_bank), .data_bank(data_bank), .p2_low(p2_low),
        .code_top(p1_code_top), .data_sel_n(p1_data_sel_n),
        .cart_en_n(p1_cart_en_n), .psen_n(psen_n), .rd_n(rd_n),
        .rom_addr_hi(rom_addr_hi), .rom_oe_n(rom_oe_n), .data_rd(data_rd)
    );

    assign bus_oe  = !rd_n && p1_data_sel_n && !p1_cart_en_n && in_window;
    assign bus_out = rdata;
    assign tx      = !out_bits[0];
    assign ee_cs   = out_bits[1];
    assign ee_clk  = out_bits[2];
    assign ee_di   = out_bits[3];

    // R9: register readback and ROM never drive together
    a_r9_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && psen_n) |-> rom_oe_n);

    // R4: top-bank forcing outside a data read
    a_r4_top_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (p1_code_top && !data_rd) |-> (rom_addr_hi[BW+PW-1:PW] == '1));

    // R8: a disabled cartridge never enables the ROM from RD
    a_r8_no_rom_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (p1_cart_en_n && psen_n) |-> (rom_oe_n && !bus_oe));
endmodule

// File: tb/sim_cart_bank_ctrl.sv
module sim_cart_bank_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_in = 8'h00;
    logic [7:0]  bus_out;
    logic        bus_oe;
    logic        ale = 1'b0, psen_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic        p1_code_top = 1'b1, p1_data_sel_n = 1'b1, p1_cart_en_n = 1'b1;
    logic [3:0]  p2_low = 4'h0;
    logic        ee_do = 1'b0;
    logic [11:0] rom_addr_hi;
    logic        rom_oe_n, tx, ee_cs, ee_clk, ee_di;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] m_code = 8'h00, m_data = 8'h00;
    logic [3:0] m_out  = 4'h0;

    always #2 clk = ~clk;

    cart_bank_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
        .p1_code_top(p1_code_top), .p1_data_sel_n(p1_data_sel_n),
        .p1_cart_en_n(p1_cart_en_n), .p2_low(p2_low), .ee_do(ee_do),
        .rom_addr_hi(rom_addr_hi), .rom_oe_n(rom_oe_n), .tx(tx),
        .ee_cs(ee_cs), .ee_clk(ee_clk), .ee_di(ee_di)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_reg(input logic [1:0] idx);
        case (idx)
            2'd0:    return m_code;
            2'd1:    return m_data;
            2'd2:    return {4'h0, m_out};
            default: return {7'b0, ee_do};
        endcase
    endfunction

    function automatic logic [11:0] exp_addr(input logic data_read);
        logic [7:0] b;
        if (data_read)        b = m_data;
        else if (p1_code_top) b = 8'hFF;
        else                  b = m_code;
        return {b, p2_low};
    endfunction

    task automatic addr_phase(input logic [7:0] a);
        @(negedge clk); bus_in = a; ale = 1'b1;
        @(negedge clk); ale = 1'b0;
        @(negedge clk); bus_in = 8'h00;
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        addr_phase(a);
        bus_in = d; wr_n = 1'b0;
        @(negedge clk);
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk); bus_in = 8'h00;
        if (!p1_cart_en_n && a[7]) begin
            case (a[1:0])
                2'd0: m_code = d;
                2'd1: m_data = d;
                2'd2: m_out  = d[3:0];
                default: ;
            endcase
        end
    endtask

    task automatic do_read(input logic [7:0] a, input string tag);
        logic drd, oe;
        addr_phase(a);
        rd_n = 1'b0;
        #1;
        drd = !p1_data_sel_n && !p1_cart_en_n;
        oe  = p1_data_sel_n && !p1_cart_en_n && a[7];
        chk({tag, " bus_oe"}, bus_oe, oe);
        if (oe) chk({tag, " bus_out"}, bus_out, exp_reg(a[1:0]));
        chk({tag, " rom_oe_n"}, rom_oe_n, !drd);
        chk({tag, " rom_addr_hi"}, rom_addr_hi, exp_addr(drd));
        @(negedge clk); rd_n = 1'b1;
    endtask

    task automatic do_fetch(input string tag);
        @(negedge clk); psen_n = 1'b0;
        #1;
        chk({tag, " fetch rom_oe_n"}, rom_oe_n, 1'b0);
        chk({tag, " fetch rom_addr_hi"}, rom_addr_hi, exp_addr(1'b0));
        @(negedge clk); psen_n = 1'b1;
        #1;
        chk({tag, " idle rom_oe_n"}, rom_oe_n, 1'b1);
    endtask

    task automatic chk_pins(input string tag);
        #1;
        chk({tag, " tx"}, tx, !m_out[0]);
        chk({tag, " ee_cs"}, ee_cs, m_out[1]);
        chk({tag, " ee_clk"}, ee_clk, m_out[2]);
        chk({tag, " ee_di"}, ee_di, m_out[3]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_pins("R1 reset");
        do_fetch("R1 top bank after reset");

        p1_cart_en_n = 1'b0;
        // R3 readback
        do_write(8'h80, 8'h5A); do_read(8'h80, "R3 code");
        do_write(8'h81, 8'hC3); do_read(8'h81, "R3 data");
        do_write(8'h82, 8'hFF); do_read(8'h82, "R3 out upper zero");
        chk_pins("R6 all set");
        do_write(8'h82, 8'h0A); chk_pins("R6 pattern A");
        // R7 input register
        do_write(8'h83, 8'h77); ee_do = 1'b1; do_read(8'h83, "R7 ee_do high");
        ee_do = 1'b0; do_read(8'hFF, "R7 ee_do low mirror");
        do_read(8'h80, "R7 write ignored code");
        // R2 mirror and outside window
        do_write(8'h86, 8'h05); do_read(8'h82, "R2 mirror out");
        do_write(8'h40, 8'h99); do_read(8'h80, "R2 outside window");
        // R4 code bank fetch
        p1_code_top = 1'b0; p2_low = 4'h9; do_fetch("R4 code bank");
        p1_code_top = 1'b1; do_fetch("R4 forced top");
        // R5 data read
        p1_data_sel_n = 1'b0; p2_low = 4'h3; do_read(8'h12, "R5 rom data read");
        p1_data_sel_n = 1'b1;
        // R8 disabled
        p1_cart_en_n = 1'b1;
        do_write(8'h80, 8'h11); do_read(8'h80, "R8 disabled read");
        p1_data_sel_n = 1'b0; do_read(8'h00, "R8 no rom data read");
        p1_data_sel_n = 1'b1; p1_cart_en_n = 1'b0;
        do_read(8'h80, "R8 disabled write lost");

        // R9 random mixture
        for (int i = 0; i < 400; i++) begin
            logic [7:0] a, d;
            a = $urandom();
            d = $urandom();
            if ($urandom_range(3) == 0) a[7] = 1'b1;
            p1_cart_en_n  = ($urandom_range(9) == 0);
            p1_data_sel_n = ($urandom_range(3) != 0);
            p1_code_top   = $urandom_range(1);
            p2_low        = $urandom();
            ee_do         = $urandom_range(1);
            case ($urandom_range(2))
                0: do_write(a, d);
                1: do_read(a, "R9 random read");
                default: do_fetch("R9 random fetch");
            endcase
        end
        p1_cart_en_n = 1'b0; p1_data_sel_n = 1'b1;
        for (int k = 0; k < 4; k++) do_read(8'h80 + 8'(k), "R3 final sweep");
        chk_pins("R6 final");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule